// File: doc/BRIEF.md
# ADC Conversion Start Arbiter

This block decides when an analog-to-digital conversion begins and which input channel the converter samples. Software writes an 8-bit control word that carries a channel number, a start request and a hardware-trigger enable. The block then does one of two things. It starts the conversion at once, which is a software start. Or it arms itself and waits for a period-match strobe from a second timer, which is a hardware start. In both cases it emits a one-cycle start pulse toward the converter and holds a busy flag until the converter signals completion.

Two things set the behaviour apart. First, the channel number is captured only by the write that raises the start request. Second, the choice between a software start and a hardware start depends on how the writes are ordered. When the start request and the trigger enable arrive in the same write, the block arms and waits for the timer. When the start request is raised without the enable in that write, the conversion starts immediately. Setting the enable in a later write changes nothing for the conversion already running.

Top module: `adc_start_arb`

## Requirements
- R1: After synchronous reset, conv_start and busy are 0, conv_chan is 0 and rd_data is 0x00.
- R2: A write with bit 3 = 1 and bit 7 = 0 while the start request is clear starts a software conversion. In the cycle after the write edge, conv_start is 1 for exactly one cycle, busy is 1 and conv_chan equals wr_data[2:0].
- R3: A write with both bit 3 and bit 7 = 1 while the start request is clear arms the block. conv_start stays 0, busy stays 0 and rd_data bit 3 reads 1. The next trig_pm strobe makes conv_start 1 for one cycle in the following cycle, and busy becomes 1.
- R4: The channel field (rd_data[2:0] and conv_chan) changes only on a write that raises bit 3 from 0. All other writes leave it unchanged.
- R5: trig_pm has no effect unless the block is armed. While the block is idle or busy, it produces no conv_start.
- R6: conv_done while busy clears busy and rd_data bit 3 in the next cycle. conv_done while armed or idle has no effect.
- R7: rd_data bit 7 holds the value of bit 7 from the last write. Setting it after a software start has already begun produces no further conv_start.
- R8: Writing 0 to bit 3 does not cancel an armed or running conversion.
- R9: Writing 0x8C while idle arms a hardware-triggered conversion on channel 4.
- R10: A trig_pm strobe in the same cycle as the arming write does not start the conversion. The conversion waits for a later strobe.
- R11: rd_data bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: [2:0] channel, [3] start request, [7] hardware-trigger enable |
| rd_data | output | 8 | Control word readback |
| trig_pm | input | 1 | Period-match strobe from the second timer |
| conv_done | input | 1 | Converter finished the conversion |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Latched channel number for the converter |
| busy | output | 1 | Conversion in progress |

## Verification
The arming write and a timer strobe can land on the same clock edge. The bench provokes this by driving wr_en with 0x8E together with trig_pm, and it requires that no start pulse follows and that the block reads back as armed. A conversion-done indication and a timer strobe can also coincide while a conversion runs. That case is judged by busy falling with no new start pulse, because the strobe found the block busy rather than armed.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;

    localparam int DATA_W    = 8;
    localparam int CHAN_W    = 3;
    localparam int START_POS = 3;
    localparam int TRIG_POS  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic              trig_en;
        logic              start;
        logic [CHAN_W-1:0] chan;
    } ctrl_fields_t;

    function automatic ctrl_fields_t split_word(input logic [DATA_W-1:0] w);
        ctrl_fields_t f;
        f.trig_en = w[TRIG_POS];
        f.start   = w[START_POS];
        f.chan    = w[CHAN_W-1:0];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] join_word(input ctrl_fields_t f);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[TRIG_POS]     = f.trig_en;
        w[START_POS]    = f.start;
        w[CHAN_W-1:0]   = f.chan;
        return w;
    endfunction

endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_start_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_active,
    output logic [CHAN_W-1:0] chan,
    output logic              trig_en,
    output logic              raise_req,
    output logic              raise_hw
);

    ctrl_fields_t wf;

    always_comb begin
        wf        = split_word(wr_data);
        raise_req = wr_en && wf.start && !req_active;
        raise_hw  = raise_req && wf.trig_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan    <= '0;
            trig_en <= 1'b0;
        end else if (wr_en) begin
            trig_en <= wf.trig_en;
            if (raise_req) begin
                chan <= wf.chan;
            end
        end
    end

endmodule

// File: rtl/adc_start_fsm.sv
module adc_start_fsm
    import adc_start_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise_req,
    input  logic raise_hw,
    input  logic trig_pm,
    input  logic conv_done,
    output logic conv_start,
    output logic armed,
    output logic busy
);

    arb_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (raise_hw) begin
                        state_q <= ST_ARMED;
                    end else if (raise_req) begin
                        state_q    <= ST_BUSY;
                        conv_start <= 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (trig_pm) begin
                        state_q    <= ST_BUSY;
                        conv_start <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (conv_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign armed = (state_q == ST_ARMED);
    assign busy  = (state_q == ST_BUSY);

endmodule

// File: rtl/adc_start_arb.sv
module adc_start_arb
    import adc_start_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              trig_pm,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              busy
);

    logic         armed;
    logic         trig_en;
    logic         raise_req;
    logic         raise_hw;
    logic         req_active;
    ctrl_fields_t rd_f;

    assign req_active = armed || busy;

    adc_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .req_active (req_active),
        .chan       (conv_chan),
        .trig_en    (trig_en),
        .raise_req  (raise_req),
        .raise_hw   (raise_hw)
    );

    adc_start_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .raise_req  (raise_req),
        .raise_hw   (raise_hw),
        .trig_pm    (trig_pm),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .armed      (armed),
        .busy       (busy)
    );

    always_comb begin
        rd_f.trig_en = trig_en;
        rd_f.start   = req_active;
        rd_f.chan    = conv_chan;
        rd_data      = join_word(rd_f);
    end

endmodule

// File: rtl/adc_start_arb_chk.sv
module adc_start_arb_chk
    import adc_start_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              trig_pm,
    input logic              conv_done,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              busy
);

    // R2: a start pulse always comes with busy and lasts one cycle
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R3: an arming write yields no pulse and leaves the request pending
    assert_arm_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[START_POS] && wr_data[TRIG_POS] && !rd_data[START_POS])
        |=> (!conv_start && !busy && rd_data[START_POS]));

    // R4: channel moves only on a write that raises the request
    assert_chan_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_data[START_POS] && !rd_data[START_POS]) |=> $stable(conv_chan));

    // R5: a strobe during a running conversion starts nothing
    assert_busy_no_start_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> !conv_start);

    // R6: done while busy releases the block
    assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_done) |=> (!busy && !rd_data[START_POS]));

    // R11: unused bits read zero
    assert_zero_bits_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:4] == 3'b000);

endmodule

bind adc_start_arb adc_start_arb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .trig_pm    (trig_pm),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy)
);

// File: tb/adc_start_arb_tb.sv
module adc_start_arb_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       trig_pm;
    logic       conv_done;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_start_arb u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .trig_pm    (trig_pm),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .busy       (busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs; returns at the following falling edge
    task automatic step(input bit we, input logic [7:0] d, input bit trig, input bit done);
        @(negedge clk);
        wr_en = we; wr_data = d; trig_pm = trig; conv_done = done;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; trig_pm = 1'b0; conv_done = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; trig_pm = 1'b0; conv_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 conv_start", {7'd0, conv_start}, 8'h00);
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 conv_chan", {5'd0, conv_chan}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_software_start;
        step(1'b1, 8'h0D, 1'b0, 1'b0);
        chk("R2 pulse", {7'd0, conv_start}, 8'h01);
        chk("R2 busy", {7'd0, busy}, 8'h01);
        chk("R2 chan", {5'd0, conv_chan}, 8'h05);
        chk("R11 rd_data", rd_data, 8'h0D);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R2 pulse width", {7'd0, conv_start}, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5 strobe while busy", {7'd0, conv_start}, 8'h00);
        step(1'b1, 8'h0A, 1'b0, 1'b0);
        chk("R4 chan held", {5'd0, conv_chan}, 8'h05);
        chk("R4 no pulse", {7'd0, conv_start}, 8'h00);
        step(1'b1, 8'h80, 1'b0, 1'b0);
        chk("R7 R8 rd_data", rd_data, 8'h8D);
        chk("R8 busy", {7'd0, busy}, 8'h01);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 busy cleared", {7'd0, busy}, 8'h00);
        chk("R6 rd_data", rd_data, 8'h85);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5 strobe while idle", {7'd0, conv_start}, 8'h00);
        chk("R5 idle busy", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_hw_arm;
        step(1'b1, 8'h8C, 1'b0, 1'b0);
        chk("R9 R3 no pulse", {7'd0, conv_start}, 8'h00);
        chk("R3 busy", {7'd0, busy}, 8'h00);
        chk("R9 rd_data", rd_data, 8'h8C);
        chk("R9 chan", {5'd0, conv_chan}, 8'h04);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h00, 1'b0, 1'b0);
            chk("R3 waiting", {7'd0, conv_start}, 8'h00);
        end
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 done while armed", rd_data, 8'h8C);
        step(1'b1, 8'h80, 1'b0, 1'b0);
        chk("R8 armed kept", rd_data, 8'h8C);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R3 pulse on strobe", {7'd0, conv_start}, 8'h01);
        chk("R3 busy", {7'd0, busy}, 8'h01);
        chk("R9 chan", {5'd0, conv_chan}, 8'h04);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R3 pulse width", {7'd0, conv_start}, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R5 R6 done with strobe", {7'd0, busy}, 8'h00);
        chk("R5 no restart", {7'd0, conv_start}, 8'h00);
        chk("R6 rd_data", rd_data, 8'h84);
    endtask

    task automatic t_order;
        step(1'b1, 8'h0B, 1'b0, 1'b0);
        chk("R2 start before enable", {7'd0, conv_start}, 8'h01);
        chk("R2 chan", {5'd0, conv_chan}, 8'h03);
        step(1'b1, 8'h88, 1'b0, 1'b0);
        chk("R7 late enable no pulse", {7'd0, conv_start}, 8'h00);
        chk("R7 rd_data", rd_data, 8'h8B);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 rd_data", rd_data, 8'h83);
    endtask

    task automatic t_collision;
        step(1'b1, 8'h8E, 1'b1, 1'b0);
        chk("R10 no pulse", {7'd0, conv_start}, 8'h00);
        chk("R10 armed", rd_data, 8'h8E);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R10 later strobe", {7'd0, conv_start}, 8'h01);
        chk("R10 chan", {5'd0, conv_chan}, 8'h06);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 busy", {7'd0, busy}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_software_start();
        t_hw_arm();
        t_order();
        t_collision();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule